// File: doc/BRIEF.md
# AHB to APB bridge

This block sits on a system bus as an AHB slave and acts as the only master of a peripheral bus. It converts each single AHB read or write into one two-cycle APB access. The first cycle is setup and the second is enable. The bridge stalls the AHB master by holding HREADY low while the peripheral access is running.

When the bridge accepts a transfer, it stores the address and direction. Address bits [15:12] select one of four peripherals through a one-hot select vector. Write data is taken from the AHB data phase, so a write spends one extra cycle before its setup cycle. Read data from the selected peripheral is registered in the enable cycle and presented on HRDATA when HREADY returns high.

An address whose select field lies outside the mapped range starts no peripheral access. Such a transfer completes at once, and a read of it returns zero. Both buses share one clock and one active-low asynchronous reset.

Top module: `ahb2apb_bridge`

## Requirements
- R1: Every peripheral access is exactly two cycles. In the setup cycle one select is high and penable is low. In the enable cycle the same select and penable are both high. In the following cycle both are low.
- R2: paddr equals the address stored when the transfer was accepted and stays unchanged from setup through enable. pwrite equals the stored hwrite (1 = write, 0 = read).
- R3: A select field haddr[15:12] = k with k in 0..3 raises only psel[k]. At no time is more than one select bit high.
- R4: On a write, pwdata equals the hwdata presented in the cycle after acceptance. The setup cycle begins one cycle after that data phase starts.
- R5: On a read, hrdata equals the prdata that the peripheral returned in the enable cycle. hrdata is valid in the first cycle with hready high again.
- R6: hready is high whenever the bridge is idle. After a mapped transfer is accepted, hready stays low for 2 cycles on a read and 3 cycles on a write, then returns high.
- R7: A transfer is accepted only when hsel is 1 and htrans is NONSEQ (2'b10) or SEQ (2'b11) while hready is high. IDLE (2'b00), BUSY (2'b01) or hsel low start no access and leave hready high.
- R8: A select field of 4 to 15 raises no select and no penable. The transfer completes with no wait state, and a read of it returns hrdata = 0.
- R9: hresp is always OKAY (2'b00).
- R10: While hresetn is low, and at once when it falls in the middle of an access, psel and penable are 0 and hready is 1.
- R11: A transfer presented in the cycle in which hready returns high after a previous transfer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Shared clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select from the system decoder |
| haddr | input | ADDR_W | AHB address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hwdata | input | DATA_W | AHB write data (data phase) |
| hrdata | output | DATA_W | AHB read data |
| hready | output | 1 | Transfer complete / stall when low |
| hresp | output | 2 | Response, always OKAY |
| paddr | output | ADDR_W | Peripheral address |
| psel | output | NSLV | One-hot peripheral selects |
| penable | output | 1 | Enable-cycle strobe |
| pwrite | output | 1 | Peripheral direction |
| pwdata | output | DATA_W | Peripheral write data |
| prdata | input | DATA_W | Peripheral read data |

## Verification
The bound checker watches the peripheral-side sequencing on every cycle. It checks that setup is always followed by enable with the same select, that penable never appears without a select or lasts two cycles, and that paddr is held across the pair. It also checks that selects are one-hot-or-zero, that hready is low while any select is high, and that hresp stays OKAY. Other behaviour needs the directed scenarios: the wait-state count per direction, the write data taken from the data phase, and read data returned through the register. The same holds for decoding of each select value, unmapped addresses returning zero, IDLE/BUSY/deselected cycles being ignored, back-to-back acceptance, and reset in mid-access.

// File: rtl/ahb2apb_bridge.sv
module ahb2apb_bridge #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NSLV    = 4,
  parameter int SEL_LSB = 12,
  parameter int SEL_W   = 4
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] hrdata,
  output logic              hready,
  output logic [1:0]        hresp,
  output logic [ADDR_W-1:0] paddr,
  output logic [NSLV-1:0]   psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata
);

  localparam logic [SEL_W:0] NSLV_W = (SEL_W+1)'(NSLV);
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WDATA, ST_SETUP, ST_ACCESS, ST_DONE
  } st_t;

  st_t                state, nxt;
  logic [ADDR_W-1:0]  addr_q;
  logic               wr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [NSLV-1:0]    dec;
  logic [SEL_W-1:0]   idx_q;
  logic               take, hit_in;

  assign hready = (state == ST_IDLE) || (state == ST_DONE);
  assign take   = hready && hsel && (htrans == TR_NSEQ || htrans == TR_SEQ);
  assign hit_in = {1'b0, haddr[SEL_LSB +: SEL_W]} < NSLV_W;
  assign idx_q  = addr_q[SEL_LSB +: SEL_W];

  for (genvar i = 0; i < NSLV; i++) begin : g_dec
    assign dec[i] = (idx_q == SEL_W'(i));
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE, ST_DONE: begin
        if (take) begin
          if (!hit_in)     nxt = ST_DONE;
          else if (hwrite) nxt = ST_WDATA;
          else             nxt = ST_SETUP;
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_WDATA:  nxt = ST_SETUP;
      ST_SETUP:  nxt = ST_ACCESS;
      ST_ACCESS: nxt = ST_DONE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) state <= ST_IDLE;
    else          state <= nxt;
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
    end else if (take) begin
      addr_q <= haddr;
      wr_q   <= hwrite;
    end
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn)               wdata_q <= '0;
    else if (state == ST_WDATA) wdata_q <= hwdata;
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn)                          rdata_q <= '0;
    else if (take && !hit_in)              rdata_q <= '0;
    else if (state == ST_ACCESS && !wr_q)  rdata_q <= prdata;
  end

  assign psel    = (state == ST_SETUP || state == ST_ACCESS) ? dec : '0;
  assign penable = (state == ST_ACCESS);
  assign paddr   = addr_q;
  assign pwrite  = wr_q;
  assign pwdata  = wdata_q;
  assign hrdata  = rdata_q;
  assign hresp   = 2'b00;

endmodule

module ahb2apb_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int NSLV   = 4
) (
  input logic              hclk,
  input logic              hresetn,
  input logic              hready,
  input logic [1:0]        hresp,
  input logic [ADDR_W-1:0] paddr,
  input logic [NSLV-1:0]   psel,
  input logic              penable
);

  // R3
  onehot_sel_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    $onehot0(psel));

  // R1
  setup_then_enable_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (psel != '0 && !penable) |=> (penable && $stable(psel)));

  // R1
  enable_needs_sel_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    penable |-> (psel != '0));

  // R1
  enable_single_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    penable |=> (!penable && psel == '0));

  // R2
  addr_hold_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    penable |-> $stable(paddr));

  // R6
  stall_during_access_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (psel != '0) |-> !hready);

  // R9
  resp_okay_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    hresp == 2'b00);

endmodule

bind ahb2apb_bridge ahb2apb_bridge_chk #(.ADDR_W(ADDR_W), .NSLV(NSLV)) u_chk (
  .hclk(hclk), .hresetn(hresetn), .hready(hready), .hresp(hresp),
  .paddr(paddr), .psel(psel), .penable(penable)
);

// File: tb/test_ahb2apb_bridge.sv
`timescale 1ns/1ps
module test_ahb2apb_bridge;
  localparam logic [31:0] RMASK = 32'h5A5A_0F0F;

  logic        hclk = 1'b0, hresetn = 1'b0;
  logic        hsel = 1'b0, hwrite = 1'b0;
  logic [31:0] haddr = '0, hwdata = '0, hrdata, paddr, pwdata, prdata;
  logic [1:0]  htrans = 2'b00, hresp;
  logic        hready, penable, pwrite;
  logic [3:0]  psel;
  int checks = 0, errors = 0;

  ahb2apb_bridge i_ahb2apb_bridge (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hwdata(hwdata), .hrdata(hrdata), .hready(hready), .hresp(hresp),
    .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite), .pwdata(pwdata),
    .prdata(prdata)
  );

  assign prdata = (psel != '0) ? (paddr ^ RMASK) : 32'hDEAD_BEEF;

  always #4 hclk = ~hclk;

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge hclk); @(negedge hclk);
  endtask

  task automatic drive_idle();
    hsel = 1'b0; htrans = 2'b00;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input int k);
    chk(hready == 1'b1, "R11 hready before write", 32'(hready), 1);
    hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = 1'b1;
    cyc();
    drive_idle(); hwdata = d; haddr = 32'hFFFF_FFFF;
    chk(hready == 1'b0 && psel == 4'b0, "R4 data phase wait", {27'b0, hready, psel}, 0);
    cyc();
    hwdata = ~d;
    chk(psel == 4'(1 << k) && !penable, "R1 R3 write setup", {27'b0, penable, psel}, 32'(1 << k));
    chk(paddr == a && pwrite == 1'b1, "R2 write addr/dir", paddr, a);
    chk(pwdata == d, "R4 pwdata", pwdata, d);
    chk(hready == 1'b0, "R6 write stall setup", 32'(hready), 0);
    cyc();
    chk(psel == 4'(1 << k) && penable, "R1 write enable", {27'b0, penable, psel}, 32'(16 | (1 << k)));
    chk(paddr == a && pwdata == d, "R2 hold", paddr, a);
    chk(hready == 1'b0, "R6 write stall enable", 32'(hready), 0);
    cyc();
    chk(hready == 1'b1 && psel == 4'b0 && !penable, "R6 write done", {27'b0, hready, psel}, 16);
  endtask

  task automatic do_read(input logic [31:0] a, input int k);
    chk(hready == 1'b1, "R11 hready before read", 32'(hready), 1);
    hsel = 1'b1; htrans = 2'b11; haddr = a; hwrite = 1'b0;
    cyc();
    drive_idle(); haddr = 32'h0;
    chk(psel == 4'(1 << k) && !penable && !pwrite, "R1 R3 read setup", {27'b0, penable, psel}, 32'(1 << k));
    chk(paddr == a, "R2 read addr", paddr, a);
    chk(hready == 1'b0, "R6 read stall setup", 32'(hready), 0);
    cyc();
    chk(penable && psel == 4'(1 << k) && hready == 1'b0, "R1 R6 read enable", {27'b0, penable, psel}, 32'(16 | (1 << k)));
    cyc();
    chk(hready == 1'b1 && psel == 4'b0, "R6 read done", {27'b0, hready, psel}, 16);
    chk(hrdata == (a ^ RMASK), "R5 hrdata", hrdata, a ^ RMASK);
  endtask

  task automatic do_unmapped(input logic [31:0] a, input logic wr);
    hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = wr; hwdata = 32'h1234_5678;
    cyc();
    drive_idle();
    chk(hready == 1'b1 && psel == 4'b0 && !penable, "R8 unmapped no access", {27'b0, hready, psel}, 16);
    if (!wr) chk(hrdata == 32'h0, "R8 unmapped read zero", hrdata, 0);
    cyc();
    chk(psel == 4'b0 && !penable && hready, "R8 unmapped stays idle", {27'b0, hready, psel}, 16);
  endtask

  task automatic ignored(input logic s, input logic [1:0] t, input string tag);
    hsel = s; htrans = t; haddr = 32'h0000_1000; hwrite = 1'b0;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk(psel == 4'b0 && !penable && hready, tag, {27'b0, hready, psel}, 16);
    end
    drive_idle();
    cyc();
  endtask

  task automatic reset_mid();
    hsel = 1'b1; htrans = 2'b10; haddr = 32'h0000_2040; hwrite = 1'b0;
    cyc();
    drive_idle();
    #1 hresetn = 1'b0;
    #1;
    chk(psel == 4'b0 && !penable && hready, "R10 async reset mid-access", {27'b0, hready, psel}, 16);
    cyc();
    hresetn = 1'b1;
    cyc();
  endtask

  initial begin
    @(negedge hclk);
    chk(psel == 4'b0 && !penable && hready == 1'b1, "R10 reset state", {27'b0, hready, psel}, 16);
    chk(hresp == 2'b00, "R9 hresp", 32'(hresp), 0);
    cyc();
    hresetn = 1'b1;
    cyc();
    do_write(32'h0000_0010, 32'hCAFE_0001, 0);
    do_write(32'h0000_1024, 32'hCAFE_0002, 1);
    do_read(32'h0000_2108, 2);
    do_read(32'h0000_3FFC, 3);
    do_write(32'hABCD_3000, 32'h0BAD_F00D, 3);
    do_unmapped(32'h0000_4000, 1'b0);
    do_read(32'h0000_0044, 0);
    do_unmapped(32'h0000_F00C, 1'b1);
    do_unmapped(32'h0000_5000, 1'b0);
    drive_idle(); cyc();
    ignored(1'b1, 2'b00, "R7 IDLE ignored");
    ignored(1'b1, 2'b01, "R7 BUSY ignored");
    ignored(1'b0, 2'b10, "R7 hsel low ignored");
    chk(hresp == 2'b00, "R9 hresp end", 32'(hresp), 0);
    reset_mid();
    do_read(32'h0000_1100, 1);
    drive_idle(); cyc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule